// File: doc/BRIEF.md
# Multi-Channel Selectable-Duration Input Debouncer

This block cleans up a bank of slow digital inputs such as switch contacts, relay feedback or field signals. Each input passes through a two-stage synchroniser and then a per-channel stability filter. A new level reaches the debounced output only after it has held steady for four ticks of one of four timing sources. A 2-bit code per channel picks the source. The four tick rates come from one shared prescaler that first divides the system clock down to a 1 us pulse. Three further dividers then derive the slower rates. With the default settings the four durations are roughly 3-4 us, 48-64 us, 0.75-1 ms and 6-8 ms. The phase of the first tick relative to the input edge is unknown, so each duration is a range.

Software controls the block through a small word-wide register port. Three configuration words each hold the codes for sixteen channels. A fourth address is a command location. Writing a 1 to its least significant bit returns every code to its default and restarts every channel filter. Nothing is stored there, and a read of that address returns zero.

Top module: `multi_debounce`

## Requirements
- R1: After the reset input, every configuration word reads as zero, which means every channel uses duration code 00.
- R2: Channel n takes its code from the configuration word at address n/16, bits [2*(n%16)+1 : 2*(n%16)]. A word written through the register port is returned on `cfg_rdata` one clock after its address is presented with `cfg_we` low.
- R3: With code 00, an input level that is held steady appears on `dout` no sooner than 3 and no later than 4 base periods (plus a few cycles of synchroniser latency) after the input changes. A base period is CLKS_PER_US clocks.
- R4: With code 01, the delay lies between 3 and 4 periods of US_T1 microseconds.
- R5: Code 10 gives a delay between 3 and 4 periods of US_T2 microseconds. Code 11 gives a delay between 3 and 4 periods of US_T3 microseconds.
- R6: An input pulse or bounce that returns to the current debounced level before 3 full periods of the selected source have passed leaves `dout` unchanged. The channel's stability count restarts whenever the input matches the output again.
- R7: A change to a channel's code while that channel is counting restarts its count. After the change, the full new duration must pass before `dout` moves.
- R8: A write to address 3 with bit 0 set clears all configuration words and restarts all channel filters. A write there with bit 0 clear changes nothing. Reads of address 3 always return zero.
- R9: Within six clocks after either reset ends, each `dout` bit equals its synchronised `din` level, without waiting for a debounce period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | NUM_CH | Raw asynchronous input levels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address (0..2 configuration, 3 command) |
| cfg_wdata | input | 2*CH_PER_REG | Register write data |
| cfg_rdata | output | 2*CH_PER_REG | Registered read data for `cfg_addr` |
| dout | output | NUM_CH | Debounced levels |

## Verification
The bench builds the block with CLKS_PER_US=2 and tick multiples of 4, 8 and 16 us. The four durations then span 2, 8, 16 and 32 clocks per tick, so a run can measure every code against its 3-to-4-period window many times. The bench can also place glitches just shorter than three periods. The mid-count code switch from 11 to 10 is timed so that a filter that failed to restart would visibly fire early. The full 48-channel, three-word layout is kept, so the field position of every channel, including the last bits of the third word, is exercised.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 1 << SEL_W;
  typedef logic [SEL_W-1:0] dur_sel_t;
endpackage

// File: rtl/mdb_prescale.sv
module mdb_prescale #(
  parameter int unsigned CLKS_PER_US = 100,
  parameter int unsigned US_T1       = 16,
  parameter int unsigned US_T2       = 250,
  parameter int unsigned US_T3       = 2000
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic [mdb_pkg::NUM_SRC-1:0]  tick
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  logic [PW-1:0] pcnt;
  logic          us_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt     <= '0;
      us_pulse <= 1'b0;
    end else if (pcnt == PW'(CLKS_PER_US - 1)) begin
      pcnt     <= '0;
      us_pulse <= 1'b1;
    end else begin
      pcnt     <= pcnt + 1'b1;
      us_pulse <= 1'b0;
    end
  end

  assign tick[0] = us_pulse;

  for (genvar k = 1; k < mdb_pkg::NUM_SRC; k++) begin : g_div
    localparam int unsigned DIV = (k == 1) ? US_T1 : (k == 2) ? US_T2 : US_T3;
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [DW-1:0] dcnt;
    logic          pulse;
    always_ff @(posedge clk) begin
      if (rst) begin
        dcnt  <= '0;
        pulse <= 1'b0;
      end else begin
        pulse <= 1'b0;
        if (us_pulse) begin
          if (dcnt == DW'(DIV - 1)) begin
            dcnt  <= '0;
            pulse <= 1'b1;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
      end
    end
    assign tick[k] = pulse;
  end

  if (CLKS_PER_US > 1) begin : g_chk
    AST_BASE_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
      us_pulse |=> !us_pulse); // R3
  end
endmodule

// File: rtl/mdb_regs.sv
module mdb_regs #(
  parameter int NUM_CH     = 48,
  parameter int CH_PER_REG = 16,
  parameter int NUM_REGS   = 3,
  parameter int ADDR_W     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [2*CH_PER_REG-1:0] wdata,
  output logic [2*CH_PER_REG-1:0] rdata,
  output logic [2*NUM_CH-1:0]     cfg,
  output logic                    srst_q
);
  localparam int REG_W = 2 * CH_PER_REG;
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NUM_REGS);

  logic [REG_W-1:0] regs [NUM_REGS];
  logic             cmd_hit;

  assign cmd_hit = we && (addr == CMD_ADDR) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst || cmd_hit) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
    end else if (we) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (addr == ADDR_W'(r)) regs[r] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= cmd_hit;
      rdata  <= '0;
      for (int r = 0; r < NUM_REGS; r++)
        if (addr == ADDR_W'(r)) rdata <= regs[r];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_map
    assign cfg[2*n +: 2] = regs[n / CH_PER_REG][2*(n % CH_PER_REG) +: 2];
  end

  AST_CMD_CLEARS_CFG: assert property (@(posedge clk) disable iff (rst)
    cmd_hit |=> (cfg == '0)); // R8
  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == CMD_ADDR) |=> (rdata == '0)); // R8
endmodule

// File: rtl/mdb_channel.sv
module mdb_channel #(
  parameter int STABLE_TICKS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        din,
  input  mdb_pkg::dur_sel_t           sel,
  input  logic [mdb_pkg::NUM_SRC-1:0] tick,
  output logic                        dout
);
  localparam int CW = $clog2(STABLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

  logic              s1, s2;
  logic [CW-1:0]     cnt;
  logic [1:0]        init;
  logic              init_done;
  mdb_pkg::dur_sel_t sel_q;

  assign init_done = (init == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      dout  <= 1'b0;
      cnt   <= '0;
      init  <= '0;
      sel_q <= '0;
    end else begin
      s1    <= din;
      s2    <= s1;
      sel_q <= sel;
      if (!init_done) begin
        init <= init + 1'b1;
        dout <= s2;
        cnt  <= '0;
      end else if (s2 == dout || sel != sel_q) begin
        cnt <= '0;
      end else if (tick[sel]) begin
        if (cnt == LAST) begin
          dout <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R6
  AST_IDLE_CLEARS_CNT: assert property (@(posedge clk) disable iff (rst)
    (init_done && s2 == dout) |=> (cnt == '0)); // R6
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (init_done && $past(init_done) && dout != $past(dout)) |-> $past(tick[sel])); // R3
  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (rst)
    (init_done && sel != sel_q) |=> (cnt == '0)); // R7
endmodule

// File: rtl/multi_debounce.sv
module multi_debounce #(
  parameter int          NUM_CH       = 48,
  parameter int          CH_PER_REG   = 16,
  parameter int unsigned CLKS_PER_US  = 100,
  parameter int unsigned US_T1        = 16,
  parameter int unsigned US_T2        = 250,
  parameter int unsigned US_T3        = 2000,
  parameter int          STABLE_TICKS = 4,
  localparam int         NUM_REGS     = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG,
  localparam int         ADDR_W       = $clog2(NUM_REGS + 1),
  localparam int         REG_W        = 2 * CH_PER_REG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] din,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic [NUM_CH-1:0] dout
);
  logic [mdb_pkg::NUM_SRC-1:0] tick;
  logic [2*NUM_CH-1:0]         cfg;
  logic                        srst_q;
  logic                        ch_rst;

  assign ch_rst = rst | srst_q;

  mdb_prescale #(
    .CLKS_PER_US(CLKS_PER_US), .US_T1(US_T1), .US_T2(US_T2), .US_T3(US_T3)
  ) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  mdb_regs #(
    .NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg), .srst_q(srst_q)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    mdb_channel #(.STABLE_TICKS(STABLE_TICKS)) u_ch (
      .clk(clk), .rst(ch_rst), .din(din[n]), .sel(cfg[2*n +: 2]),
      .tick(tick), .dout(dout[n])
    );
  end
endmodule

// File: tb/multi_debounce_tb.sv
module multi_debounce_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 48;
  localparam int CPU = 2;
  localparam int T1 = 4, T2 = 8, T3 = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NCH-1:0] din = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NCH-1:0] dout;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] shadow [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  multi_debounce #(.NUM_CH(NCH), .CH_PER_REG(16), .CLKS_PER_US(CPU),
                   .US_T1(T1), .US_T2(T2), .US_T3(T3), .STABLE_TICKS(4)) u_dut (
    .clk(clk), .rst(rst), .din(din), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dout(dout));

  function automatic int period(int code);
    case (code)
      0: return CPU;
      1: return CPU * T1;
      2: return CPU * T2;
      default: return CPU * T3;
    endcase
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 2'(a);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic set_code(int ch, int code);
    shadow[ch/16][2*(ch%16) +: 2] = 2'(code);
    wr(ch/16, shadow[ch/16]);
  endtask

  task automatic measure(int ch, int code, string req);
    int p = period(code);
    int n = 0;
    logic tgt;
    set_code(ch, code);
    tgt = ~din[ch];
    din[ch] = tgt;
    while (dout[ch] !== tgt && n < 4*p + 20) begin
      @(negedge clk); n++;
    end
    check(n >= 3*p && n <= 4*p + 4, req, n, 4*p);
  endtask

  task automatic glitch(int ch, int code, int w);
    int p = period(code);
    logic orig = dout[ch];
    bit moved = 0;
    set_code(ch, code);
    din[ch] = ~din[ch];
    repeat (w) @(negedge clk);
    din[ch] = ~din[ch];
    for (int i = 0; i < 4*p + 10; i++) begin
      @(negedge clk);
      if (dout[ch] !== orig) moved = 1;
    end
    check(!moved, "R6 short pulse ignored", moved, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int r = 0; r < 3; r++) shadow[r] = '0;
    din = {$urandom(), $urandom()};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(dout === din, "R9 outputs load input after reset", dout, din);
    for (int r = 0; r < 3; r++) begin
      rd(r, d);
      check(d === 32'h0, "R1 config zero after reset", d, 0);
    end

    // R2: random word writes and readback
    for (int i = 0; i < 8; i++) begin
      int a = $urandom_range(2, 0);
      shadow[a] = $urandom();
      wr(a, shadow[a]);
      rd(a, d);
      check(d === shadow[a], "R2 readback", d, shadow[a]);
    end

    // directed codes at field extremes
    measure(0, 0, "R3 code00 delay");
    measure(17, 1, "R4 code01 delay");
    measure(40, 2, "R5 code10 delay");
    measure(47, 3, "R5 code11 delay");
    measure(15, 3, "R2 top field of word0");
    measure(31, 0, "R2 top field of word1");

    // random channels/codes
    for (int i = 0; i < 14; i++) begin
      int ch = $urandom_range(NCH-1, 0);
      int cd = $urandom_range(3, 0);
      measure(ch, cd, cd == 0 ? "R3 random" : cd == 1 ? "R4 random" : "R5 random");
    end

    // glitches shorter than 3 periods
    glitch(3, 0, 3*period(0) - 2);
    glitch(44, 3, 3*period(3) - 2);
    for (int i = 0; i < 6; i++) begin
      int cd = $urandom_range(3, 0);
      glitch($urandom_range(NCH-1, 0), cd, $urandom_range(3*period(cd) - 2, 1));
    end

    // R7: code change mid-count restarts
    begin
      logic tgt, orig;
      int n = 0;
      set_code(5, 3);
      repeat (4) @(negedge clk);
      orig = dout[5];
      tgt = ~din[5];
      din[5] = tgt;
      repeat (80) @(negedge clk);
      set_code(5, 2);
      repeat (39) @(negedge clk);
      check(dout[5] === orig, "R7 no early move after code change", dout[5], orig);
      while (dout[5] !== tgt && n < 60) begin @(negedge clk); n++; end
      check(dout[5] === tgt, "R7 moves after new duration", dout[5], tgt);
    end

    // R8: command register
    for (int r = 0; r < 3; r++) begin shadow[r] = $urandom(); wr(r, shadow[r]); end
    wr(3, 32'hFFFF_FFFE);
    rd(1, d);
    check(d === shadow[1], "R8 bit0 clear has no effect", d, shadow[1]);
    rd(3, d);
    check(d === 32'h0, "R8 command reads zero", d, 0);
    din = {$urandom(), $urandom()};
    wr(3, 32'h1);
    repeat (6) @(negedge clk);
    check(dout === din, "R9 outputs load input after soft reset", dout, din);
    for (int r = 0; r < 3; r++) begin
      rd(r, d);
      check(d === 32'h0, "R8 config cleared by command", d, 0);
      shadow[r] = '0;
    end
    measure(33, 0, "R8 default code after command");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule